// File: doc/BRIEF.md
# Parallel Bit Test Mode Controller for a 1-Bit Memory

This block is the device-side control of a one-bit-wide dynamic memory with a latched parallel test mode. The row strobe, column strobe, write enable, output enable, address and data-in pins are sampled on a clock. A strobe-sequence decoder works out which kind of cycle is running from these samples. A normal access latches the row when the row strobe falls. Each column strobe fall within that row period then reads or writes one cell, so several columns can be accessed under one row. A refresh cycle starts when the column strobe is already low as the row strobe falls. A row-only refresh is a row period that ends with no column strobe fall.

A refresh cycle that has write enable low at the row-strobe fall enters test mode. The mode stays latched through any number of ordinary cycles. In test mode the top row bit and column bit 0 are ignored, so four cells are selected together. A write stores the data bit into all four cells. A read returns one compressed pass/fail bit: 1 when the four cells agree, 0 when they differ. A row-only refresh, or a refresh cycle with write enable high, ends test mode. The storage is a small synthesizable array. Analog timing is abstracted into clock samples.

Top module: `pbt_dram_core`

## Requirements
- R1: After reset the block is in normal mode, every cell holds 0 and the data output is disabled (dout_en_o = 0).
- R2: In normal mode, a column-strobe fall with write enable low stores din_i at cell {row, column}. A column-strobe fall with write enable high reads that cell. Several column accesses may follow one row-strobe fall.
- R3: dout_en_o is 1 only after a read column-strobe fall while the column strobe stays low and output enable is low. It is 0 for write cycles, while output enable is high, and after the column strobe rises.
- R4: Test mode is entered only when the column strobe and write enable are both low in the sample where the row strobe falls. Write enable going low only in a later sample does not enter test mode.
- R5: Once entered, test mode persists across any number of ordinary read and write cycles.
- R6: A row-only refresh (row strobe falls with the column strobe high, then rises with no column-strobe fall) leaves test mode.
- R7: A refresh cycle with write enable high at the row-strobe fall leaves test mode.
- R8: A test-mode write stores din_i into the four cells formed by both values of the top row-address bit and both values of column-address bit 0. No other cell changes.
- R9: A test-mode read returns 1 if the four selected cells are equal and 0 if any differ. The result is the same for every value of the two ignored address bits.
- R10: Cell contents change only on a write column-strobe fall. Refresh cycles of either kind leave every cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Multiplexed row/column address |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data or compressed test result |
| dout_en_o | output | 1 | Data output drive enable (0 = high impedance) |

## Verification
Every strobe edge is seen in the sample that first shows the new level. Read data and the drive enable are registered at that same sampling edge, so they are valid one clock after the column strobe is driven low. They drop one clock after the column strobe or output enable goes high. Mode changes take effect at the row-strobe sample and so govern the next access. The bench drives inputs on falling clock edges and samples outputs on the falling edge after the capturing rising edge. It checks test-mode entry and exit only through later read and write results. It sweeps all cells in page mode before and after refresh cycles.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_ACCESS,
    CYC_REFRESH
  } cyc_e;
endpackage

// File: rtl/pbt_strobe_dec.sv
module pbt_strobe_dec
  import pbt_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output logic          ras_q_o,
  output logic          cas_q_o,
  output logic [AW-1:0] row_o,
  output logic          acc_o,
  output logic          acc_wr_o,
  output logic          test_mode_o
);
  logic ras_q, cas_q, cas_seen_q, test_q;
  logic ras_fall, ras_rise, cas_fall;
  logic [AW-1:0] row_q;
  cyc_e cyc_q;

  assign ras_fall = ras_q & ~ras_ni;
  assign ras_rise = ~ras_q & ras_ni;
  assign cas_fall = cas_q & ~cas_ni & ~ras_ni & ~ras_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      cas_seen_q <= 1'b0;
      test_q     <= 1'b0;
      row_q      <= '0;
      cyc_q      <= CYC_IDLE;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      if (ras_fall) begin
        row_q      <= addr_i;
        cas_seen_q <= 1'b0;
        if (!cas_ni) begin
          cyc_q  <= CYC_REFRESH;
          test_q <= ~we_ni;          // entry with WE low, exit with WE high
        end else begin
          cyc_q  <= CYC_ACCESS;
        end
      end else if (ras_rise) begin
        if (cyc_q == CYC_ACCESS && !cas_seen_q) test_q <= 1'b0;  // row-only refresh
        cyc_q <= CYC_IDLE;
      end else if (cas_fall && cyc_q == CYC_ACCESS) begin
        cas_seen_q <= 1'b1;
      end
    end
  end

  assign ras_q_o     = ras_q;
  assign cas_q_o     = cas_q;
  assign row_o       = row_q;
  assign acc_o       = cas_fall && (cyc_q == CYC_ACCESS);
  assign acc_wr_o    = acc_o & ~we_ni;
  assign test_mode_o = test_q;
endmodule

// File: rtl/pbt_cell_array.sv
module pbt_cell_array
  import pbt_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  grp_i,
  input  logic [AW-1:0]         row_i,
  input  logic [AW-1:0]         col_i,
  input  logic                  din_i,
  output logic                  single_o,
  output logic [LANES-1:0]      grp_bits_o,
  output logic [(1<<(2*AW))-1:0] mem_o
);
  localparam int unsigned IW    = 2 * AW;
  localparam int unsigned DEPTH = 1 << IW;

  logic [DEPTH-1:0] mem_q;
  logic [IW-1:0]    single_idx;
  logic [IW-1:0]    lane_idx [LANES];

  assign single_idx = {row_i, col_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [1:0] LSEL = g[1:0];
    assign lane_idx[g]   = {LSEL[1], row_i[AW-2:0], col_i[AW-1:1], LSEL[0]};
    assign grp_bits_o[g] = mem_q[lane_idx[g]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_i) begin
      if (grp_i) begin
        for (int k = 0; k < LANES; k++) mem_q[lane_idx[k]] <= din_i;
      end else begin
        mem_q[single_idx] <= din_i;
      end
    end
  end

  assign single_o = mem_q[single_idx];
  assign mem_o    = mem_q;
endmodule

// File: rtl/pbt_out_stage.sv
module pbt_out_stage
  import pbt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             acc_wr_i,
  input  logic             test_i,
  input  logic             single_i,
  input  logic [LANES-1:0] grp_bits_i,
  input  logic             cas_ni,
  input  logic             oe_ni,
  output logic             dout_o,
  output logic             dout_en_o
);
  logic rd_valid_q, data_q, oe_q, cmp_pass;

  assign cmp_pass = (&grp_bits_i) | ~(|grp_bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      data_q     <= 1'b0;
      oe_q       <= 1'b1;
    end else begin
      oe_q <= oe_ni;
      if (acc_i) begin
        rd_valid_q <= ~acc_wr_i;
        if (!acc_wr_i) data_q <= test_i ? cmp_pass : single_i;
      end else if (cas_ni) begin
        rd_valid_q <= 1'b0;
      end
    end
  end

  assign dout_o    = data_q;
  assign dout_en_o = rd_valid_q & ~oe_q;
endmodule

// File: rtl/pbt_dram_core.sv
module pbt_dram_core
  import pbt_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          dout_en_o
);
  localparam int unsigned DEPTH = 1 << (2 * AW);

  logic             ras_q, cas_q, acc, acc_wr, test_mode, single_bit;
  logic [AW-1:0]    row;
  logic [LANES-1:0] grp_bits;
  logic [DEPTH-1:0] mem_bits;

  pbt_strobe_dec #(.AW(AW)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .addr_i      (addr_i),
    .ras_q_o     (ras_q),
    .cas_q_o     (cas_q),
    .row_o       (row),
    .acc_o       (acc),
    .acc_wr_o    (acc_wr),
    .test_mode_o (test_mode)
  );

  pbt_cell_array #(.AW(AW)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (acc_wr),
    .grp_i      (test_mode),
    .row_i      (row),
    .col_i      (addr_i),
    .din_i      (din_i),
    .single_o   (single_bit),
    .grp_bits_o (grp_bits),
    .mem_o      (mem_bits)
  );

  pbt_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .acc_wr_i   (acc_wr),
    .test_i     (test_mode),
    .single_i   (single_bit),
    .grp_bits_i (grp_bits),
    .cas_ni     (cas_ni),
    .oe_ni      (oe_ni),
    .dout_o     (dout_o),
    .dout_en_o  (dout_en_o)
  );
endmodule

// File: rtl/pbt_dram_core_chk.sv
module pbt_dram_core_chk #(
  parameter int unsigned AW = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ras_ni,
  input logic                   cas_ni,
  input logic                   we_ni,
  input logic                   oe_ni,
  input logic                   ras_q,
  input logic                   cas_q,
  input logic                   test_mode,
  input logic                   dout_en_o,
  input logic [(1<<(2*AW))-1:0] mem_bits
);
  assert_drive_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> (!$past(oe_ni) && !$past(cas_ni)));

  assert_entry_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode) |-> $past(ras_q && !ras_ni && !cas_ni && !we_ni));

  assert_mode_persist_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_mode) |-> $past(ras_q != ras_ni));

  assert_exit_on_ras_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(test_mode) |-> $past(ras_q != ras_ni));

  assert_cells_only_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_bits) |-> $past(cas_q && !cas_ni && !ras_ni && !we_ni));
endmodule

bind pbt_dram_core pbt_dram_core_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ras_ni    (ras_ni),
  .cas_ni    (cas_ni),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .ras_q     (ras_q),
  .cas_q     (cas_q),
  .test_mode (test_mode),
  .dout_en_o (dout_en_o),
  .mem_bits  (mem_bits)
);

// File: tb/pbt_dram_core_tb_top.sv
`timescale 1ns/1ps
module pbt_dram_core_tb_top;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pbt_dram_core #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  function automatic logic pat(int r, int c);
    return 1'(((r * 7 + c * 3 + r * c) >> 1) & 1);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic open_row(int r);
    addr = AW'(r); ras_n = 1'b0; tick();
  endtask

  task automatic close_row();
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(); tick();
  endtask

  task automatic col_write(int c, logic d);
    addr = AW'(c); din = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; tick();
    chk("R3 write drive", dout_en, 1'b0);
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic col_read(int c, output logic d, output logic en);
    addr = AW'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; tick();
    d = dout; en = dout_en;
    cas_n = 1'b1; tick();
  endtask

  task automatic wr1(int r, int c, logic d);
    open_row(r); col_write(c, d); close_row();
  endtask

  task automatic rd_chk(string req, int r, int c, logic exp);
    logic d, en;
    open_row(r); col_read(c, d, en); close_row();
    chk(req, en, 1'b1);
    chk(req, d, exp);
  endtask

  task automatic cbr(logic we_at_fall, logic we_late);
    cas_n = 1'b0; we_n = we_at_fall; tick();
    ras_n = 1'b0; tick();
    we_n = we_late; tick();
    close_row();
  endtask

  task automatic ras_only(int r);
    open_row(r); tick(); close_row();
  endtask

  task automatic sweep_read(string req);
    logic d, en;
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) begin
        col_read(c, d, en);
        chk(req, d, pat(r, c));
      end
      close_row();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic d, en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 output disabled", dout_en, 1'b0);
    rd_chk("R1 cleared cell", 3, 9, 1'b0);

    // R2 page-mode fill and readback
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) col_write(c, pat(r, c));
      close_row();
    end
    sweep_read("R2 page read");

    // R3 enable behaviour
    open_row(2);
    addr = 4'd5; oe_n = 1'b0; cas_n = 1'b0; tick();
    chk("R3 read drive", dout_en, 1'b1);
    oe_n = 1'b1; tick();
    chk("R3 oe high", dout_en, 1'b0);
    cas_n = 1'b1; oe_n = 1'b0; tick();
    chk("R3 cas high", dout_en, 1'b0);
    close_row();

    // R10 refreshes keep contents
    for (int r = 0; r < N; r++) ras_only(r);
    cbr(1'b1, 1'b1);
    sweep_read("R10 after refresh");

    // group rows {5,13} cols {6,7}: mixed
    wr1(5, 6, 1'b1); wr1(5, 7, 1'b0); wr1(13, 6, 1'b1); wr1(13, 7, 1'b1);
    cbr(1'b1, 1'b0);
    rd_chk("R4 late WE no entry", 5, 6, 1'b1);

    cbr(1'b0, 1'b0);
    rd_chk("R4 entry differ", 5, 6, 1'b0);
    rd_chk("R9 alias differ", 13, 7, 1'b0);
    wr1(13, 7, 1'b1);
    rd_chk("R5 persists", 5, 6, 1'b1);
    rd_chk("R9 alias equal", 13, 6, 1'b1);

    cbr(1'b1, 1'b1);
    rd_chk("R8 fanout 5,7", 5, 7, 1'b1);
    rd_chk("R8 fanout 13,6", 13, 6, 1'b1);
    rd_chk("R8 neighbour", 5, 4, pat(5, 4));
    rd_chk("R8 neighbour", 12, 7, pat(12, 7));
    wr1(5, 7, 1'b0);
    rd_chk("R7 exit single", 5, 7, 1'b0);
    rd_chk("R7 exit other", 5, 6, 1'b1);

    cbr(1'b0, 1'b0);
    rd_chk("R5 test read", 13, 6, 1'b0);
    rd_chk("R5 test read again", 5, 7, 1'b0);
    ras_only(9);
    rd_chk("R6 exit single", 5, 7, 1'b0);
    rd_chk("R6 exit other", 5, 6, 1'b1);

    // R9 all-zero group passes
    cbr(1'b0, 1'b0);
    wr1(8, 1, 1'b0);
    rd_chk("R9 zeros equal", 0, 0, 1'b1);
    ras_only(0);
    rd_chk("R8 zero fanout", 8, 0, 1'b0);
    rd_chk("R8 zero fanout", 0, 1, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule